// File: doc/BRIEF.md
# Lockable Status Control Register File

This block is a bank of 32-bit control and status words on a simple single-cycle register bus. The address space is split into five regions. Each region applies its own write rule: plain read/write, read-only status, per-bit lock, whole-word lock, or a half-writable word whose upper half mirrors hardware. Control bits leave the block as flat vectors, and hardware status enters it as flat vectors.

Software sets a lock by writing a 1 to a lock bit. Reading the word back shows the lock state. A lock bit can only be cleared by reset. A write that the rules forbid outright gets an error response. Addresses outside the regions also get an error response and read as zero. Each response arrives one cycle after the request, from registers.

Top module: `lockable_csr_bank`

## Requirements
- R1: Regions are decoded from the byte address. Read/write words start at 0x1000, read-only words at 0x1100, per-bit-lock words at 0x1200, word-lock words at 0x1400, and half-writable words at 0x1600. Word i of a region sits at base + 4*i for i below that region's word count (4 by default). Control word i of each output vector occupies slice [i*width +: width].
- R2: A write to a read/write word stores all 32 bits and raises no error. The word reads back unchanged and drives its slice of `rw_ctrl_o`.
- R3: A read of a read-only word returns the matching 32-bit slice of `ro_status_i`, sampled at the clock edge of the read. A write to such a word changes nothing and raises `bus_err`.
- R4: In a per-bit-lock word, bit k+16 locks data bit k (k = 0..15). A write sets every lock bit whose write-data bit is 1. It updates data bit k only if lock k was clear before the write, so a single write can load a data bit and lock it. Such writes raise no error. Data bits 15:0 drive `bl_ctrl_o`.
- R5: Lock bits are sticky. A write of 0 leaves them set, and only `rst` clears them.
- R6: In a word-lock word, bit 31 locks bits 30:0. While the lock is clear, a write loads all 32 bits. While it is set, a write changes nothing and raises `bus_err`. Bits 30:0 drive `wl_ctrl_o`.
- R7: In a half-writable word, bits 15:0 are writable and drive `hw_ctrl_o`. Bits 31:16 read the matching 16-bit slice of `hw_status_i`. Write data in bits 31:16 is ignored and raises no error.
- R8: An access that misses all regions reads 0 and raises `bus_err`. A miss is an address outside the regions, a word index at or above the region's count, or an address with bits 1:0 not zero.
- R9: `bus_rdata` and `bus_err` are registered and valid in the cycle after the request. A write is visible to a read issued in the following cycle. A request with both enables returns the contents from before the write. With no request, `bus_rdata` and `bus_err` are 0.
- R10: After reset all stored bits are 0, so every control output, `bus_rdata` and `bus_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wen | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_ren | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_err | output | 1 | Error response, one cycle after the request |
| ro_status_i | input | N_RO*32 | Hardware status for the read-only words |
| hw_status_i | input | N_HALF*16 | Hardware status for the upper halves of half-writable words |
| rw_ctrl_o | output | N_RW*32 | Read/write control words |
| bl_ctrl_o | output | N_BL*16 | Data bits of the per-bit-lock words |
| wl_ctrl_o | output | N_WL*31 | Data bits of the word-lock words |
| hw_ctrl_o | output | N_HALF*16 | Writable halves of the half-writable words |

## Verification
Every response and every control-output change is due exactly one rising edge after the request is presented. The bench drives each request on a falling edge and samples `bus_rdata`, `bus_err` and all control vectors at the next falling edge, after the one rising edge that registers them. The bench predicts read data from its own model state before applying the write, so it also checks the pre-write value returned by a combined read and write. Status inputs are changed only between accesses, so the value sampled at the read edge is known.

// File: rtl/csr_bank_pkg.sv
`timescale 1ns/1ps
package csr_bank_pkg;

  // Region base byte addresses; the decode depends on these values.
  localparam int unsigned RW_BASE   = 32'h1000;
  localparam int unsigned RO_BASE   = 32'h1100;
  localparam int unsigned BL_BASE   = 32'h1200;
  localparam int unsigned WL_BASE   = 32'h1400;
  localparam int unsigned HALF_BASE = 32'h1600;
  localparam int unsigned MAP_END   = 32'h1800;

  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_RW,
    RGN_RO,
    RGN_BITLOCK,
    RGN_WORDLOCK,
    RGN_HALF
  } region_e;

endpackage

// File: rtl/csr_addr_decode.sv
`timescale 1ns/1ps
module csr_addr_decode
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_RW   = 4,
  parameter int N_RO   = 4,
  parameter int N_BL   = 4,
  parameter int N_WL   = 4,
  parameter int N_HALF = 4,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [ADDR_W-1:0] B_RW   = ADDR_W'(RW_BASE);
  localparam logic [ADDR_W-1:0] B_RO   = ADDR_W'(RO_BASE);
  localparam logic [ADDR_W-1:0] B_BL   = ADDR_W'(BL_BASE);
  localparam logic [ADDR_W-1:0] B_WL   = ADDR_W'(WL_BASE);
  localparam logic [ADDR_W-1:0] B_HALF = ADDR_W'(HALF_BASE);
  localparam logic [ADDR_W-1:0] B_END  = ADDR_W'(MAP_END);

  localparam logic [ADDR_W-1:0] L_RW   = ADDR_W'(N_RW);
  localparam logic [ADDR_W-1:0] L_RO   = ADDR_W'(N_RO);
  localparam logic [ADDR_W-1:0] L_BL   = ADDR_W'(N_BL);
  localparam logic [ADDR_W-1:0] L_WL   = ADDR_W'(N_WL);
  localparam logic [ADDR_W-1:0] L_HALF = ADDR_W'(N_HALF);

  region_e           cand;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] word;
  logic [ADDR_W-1:0] lim;

  always_comb begin
    cand = RGN_NONE;
    off  = '0;
    lim  = '0;
    if (addr >= B_RW && addr < B_RO) begin
      cand = RGN_RW;       off = addr - B_RW;   lim = L_RW;
    end else if (addr >= B_RO && addr < B_BL) begin
      cand = RGN_RO;       off = addr - B_RO;   lim = L_RO;
    end else if (addr >= B_BL && addr < B_WL) begin
      cand = RGN_BITLOCK;  off = addr - B_BL;   lim = L_BL;
    end else if (addr >= B_WL && addr < B_HALF) begin
      cand = RGN_WORDLOCK; off = addr - B_WL;   lim = L_WL;
    end else if (addr >= B_HALF && addr < B_END) begin
      cand = RGN_HALF;     off = addr - B_HALF; lim = L_HALF;
    end
    word   = off >> 2;
    region = (cand != RGN_NONE && addr[1:0] == 2'b00 && word < lim) ? cand : RGN_NONE;
    idx    = word[IDX_W-1:0];
  end

endmodule

// File: rtl/csr_lock_word.sv
`timescale 1ns/1ps
module csr_lock_word
  import csr_bank_pkg::*;
#(
  parameter region_e KIND = RGN_RW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word
);

  generate
    if (KIND == RGN_BITLOCK) begin : g_bitlock
      logic [HALF_W-1:0] lock_q;
      logic [HALF_W-1:0] data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          lock_q <= '0;
          data_q <= '0;
        end else if (wr_en) begin
          lock_q <= lock_q | wdata[WORD_W-1:HALF_W];
          data_q <= (data_q & lock_q) | (wdata[HALF_W-1:0] & ~lock_q);
        end
      end
      assign rd_word = {lock_q, data_q};

      AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));  // R5
      AST_LOCKED_BIT_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((data_q & $past(lock_q)) == ($past(data_q) & $past(lock_q))));  // R4

    end else if (KIND == RGN_WORDLOCK) begin : g_wordlock
      logic              lock_q;
      logic [WORD_W-2:0] data_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          lock_q <= 1'b0;
          data_q <= '0;
        end else if (wr_en && !lock_q) begin
          lock_q <= wdata[WORD_W-1];
          data_q <= wdata[WORD_W-2:0];
        end
      end
      assign rd_word = {lock_q, data_q};

      AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (lock_q && $stable(data_q)));  // R6

    end else if (KIND == RGN_HALF) begin : g_half
      logic [HALF_W-1:0] lo_q;
      logic              unused_hi;

      always_ff @(posedge clk) begin
        if (rst) lo_q <= '0;
        else if (wr_en) lo_q <= wdata[HALF_W-1:0];
      end
      assign rd_word   = {{(WORD_W-HALF_W){1'b0}}, lo_q};
      assign unused_hi = ^wdata[WORD_W-1:HALF_W];

    end else begin : g_plain
      logic [WORD_W-1:0] word_q;

      always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else if (wr_en) word_q <= wdata;
      end
      assign rd_word = word_q;
    end
  endgenerate

endmodule

// File: rtl/lockable_csr_bank.sv
`timescale 1ns/1ps
module lockable_csr_bank
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int N_RW   = 4,
  parameter int N_RO   = 4,
  parameter int N_BL   = 4,
  parameter int N_WL   = 4,
  parameter int N_HALF = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wen,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_ren,
  output logic [31:0]              bus_rdata,
  output logic                     bus_err,
  input  logic [N_RO*32-1:0]       ro_status_i,
  input  logic [N_HALF*16-1:0]     hw_status_i,
  output logic [N_RW*32-1:0]       rw_ctrl_o,
  output logic [N_BL*16-1:0]       bl_ctrl_o,
  output logic [N_WL*31-1:0]       wl_ctrl_o,
  output logic [N_HALF*16-1:0]     hw_ctrl_o
);

  localparam int W     = WORD_W;
  localparam int H     = HALF_W;
  localparam int MAX_A = (N_RW > N_RO) ? N_RW : N_RO;
  localparam int MAX_B = (N_BL > N_WL) ? N_BL : N_WL;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_N = (MAX_C > N_HALF) ? MAX_C : N_HALF;
  localparam int IDX_W = (MAX_N > 1) ? $clog2(MAX_N) : 1;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     rw_q   [N_RW];
  logic [W-1:0]     bl_q   [N_BL];
  logic [W-1:0]     wl_q   [N_WL];
  logic [W-1:0]     half_q [N_HALF];
  logic [N_HALF-1:0] unused_half_hi;
  logic [W-1:0]     sel_word;
  logic             wl_locked;
  logic             access;
  logic             err_d;

  csr_addr_decode #(
    .ADDR_W(ADDR_W), .N_RW(N_RW), .N_RO(N_RO), .N_BL(N_BL),
    .N_WL(N_WL), .N_HALF(N_HALF), .IDX_W(IDX_W)
  ) u_decode (
    .addr   (bus_addr),
    .region (region),
    .idx    (idx)
  );

  generate
    for (genvar i = 0; i < N_RW; i++) begin : g_rw
      csr_lock_word #(.KIND(RGN_RW)) u_word (
        .clk(clk), .rst(rst),
        .wr_en(bus_wen && region == RGN_RW && idx == IDX_W'(i)),
        .wdata(bus_wdata), .rd_word(rw_q[i])
      );
      assign rw_ctrl_o[i*W +: W] = rw_q[i];
    end
    for (genvar i = 0; i < N_BL; i++) begin : g_bl
      csr_lock_word #(.KIND(RGN_BITLOCK)) u_word (
        .clk(clk), .rst(rst),
        .wr_en(bus_wen && region == RGN_BITLOCK && idx == IDX_W'(i)),
        .wdata(bus_wdata), .rd_word(bl_q[i])
      );
      assign bl_ctrl_o[i*H +: H] = bl_q[i][H-1:0];
    end
    for (genvar i = 0; i < N_WL; i++) begin : g_wl
      csr_lock_word #(.KIND(RGN_WORDLOCK)) u_word (
        .clk(clk), .rst(rst),
        .wr_en(bus_wen && region == RGN_WORDLOCK && idx == IDX_W'(i)),
        .wdata(bus_wdata), .rd_word(wl_q[i])
      );
      assign wl_ctrl_o[i*(W-1) +: (W-1)] = wl_q[i][W-2:0];
    end
    for (genvar i = 0; i < N_HALF; i++) begin : g_half
      csr_lock_word #(.KIND(RGN_HALF)) u_word (
        .clk(clk), .rst(rst),
        .wr_en(bus_wen && region == RGN_HALF && idx == IDX_W'(i)),
        .wdata(bus_wdata), .rd_word(half_q[i])
      );
      assign hw_ctrl_o[i*H +: H] = half_q[i][H-1:0];
      assign unused_half_hi[i]   = ^half_q[i][W-1:H];
    end
  endgenerate

  // Read-side selection; status inputs are taken live at the read edge.
  always_comb begin
    sel_word  = '0;
    wl_locked = 1'b0;
    case (region)
      RGN_RW:
        for (int i = 0; i < N_RW; i++)
          if (idx == IDX_W'(i)) sel_word = rw_q[i];
      RGN_RO:
        for (int i = 0; i < N_RO; i++)
          if (idx == IDX_W'(i)) sel_word = ro_status_i[i*W +: W];
      RGN_BITLOCK:
        for (int i = 0; i < N_BL; i++)
          if (idx == IDX_W'(i)) sel_word = bl_q[i];
      RGN_WORDLOCK:
        for (int i = 0; i < N_WL; i++)
          if (idx == IDX_W'(i)) begin
            sel_word  = wl_q[i];
            wl_locked = wl_q[i][W-1];
          end
      RGN_HALF:
        for (int i = 0; i < N_HALF; i++)
          if (idx == IDX_W'(i)) sel_word = {hw_status_i[i*H +: H], half_q[i][H-1:0]};
      default: ;
    endcase
  end

  assign access = bus_wen | bus_ren;
  assign err_d  = (access && region == RGN_NONE)
               || (bus_wen && region == RGN_RO)
               || (bus_wen && region == RGN_WORDLOCK && wl_locked);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= bus_ren ? sel_word : '0;
      bus_err   <= err_d;
    end
  end

  AST_RO_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && region == RGN_RO) |=> bus_err);  // R3
  AST_UNMAPPED_ERR: assert property (@(posedge clk) disable iff (rst)
    (access && region == RGN_NONE) |=> (bus_err && bus_rdata == '0));  // R8
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !access |=> (!bus_err && bus_rdata == '0));  // R9
  AST_RW_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && region == RGN_RW) |=> !bus_err);  // R2

endmodule

// File: tb/lockable_csr_bank_tb.sv
`timescale 1ns/1ps
module lockable_csr_bank_tb;

  localparam int N = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic [15:0]       bus_addr;
  logic              bus_wen;
  logic [31:0]       bus_wdata;
  logic              bus_ren;
  logic [31:0]       bus_rdata;
  logic              bus_err;
  logic [N*32-1:0]   ro_status_i;
  logic [N*16-1:0]   hw_status_i;
  logic [N*32-1:0]   rw_ctrl_o;
  logic [N*16-1:0]   bl_ctrl_o;
  logic [N*31-1:0]   wl_ctrl_o;
  logic [N*16-1:0]   hw_ctrl_o;

  always #2.5 clk = ~clk;

  lockable_csr_bank #(
    .ADDR_W(16), .N_RW(N), .N_RO(N), .N_BL(N), .N_WL(N), .N_HALF(N)
  ) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .ro_status_i(ro_status_i), .hw_status_i(hw_status_i),
    .rw_ctrl_o(rw_ctrl_o), .bl_ctrl_o(bl_ctrl_o), .wl_ctrl_o(wl_ctrl_o),
    .hw_ctrl_o(hw_ctrl_o)
  );

  // Reference state built from the requirements.
  logic [31:0] m_rw    [N];
  logic [15:0] m_bl_lk [N];
  logic [15:0] m_bl_d  [N];
  logic        m_wl_lk [N];
  logic [30:0] m_wl_d  [N];
  logic [15:0] m_hl    [N];

  int n_vec = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int base_of(input int rg);
    case (rg)
      1: return 32'h1000;
      2: return 32'h1100;
      3: return 32'h1200;
      4: return 32'h1400;
      5: return 32'h1600;
      default: return 0;
    endcase
  endfunction

  // R1: region and word index from the byte address.
  task automatic classify(input logic [15:0] a, output int rg, output int wi);
    int ai;
    ai = int'(a);
    rg = 0;
    wi = 0;
    if (ai >= 32'h1000 && ai < 32'h1100) rg = 1;
    else if (ai >= 32'h1100 && ai < 32'h1200) rg = 2;
    else if (ai >= 32'h1200 && ai < 32'h1400) rg = 3;
    else if (ai >= 32'h1400 && ai < 32'h1600) rg = 4;
    else if (ai >= 32'h1600 && ai < 32'h1800) rg = 5;
    if (rg != 0) begin
      wi = (ai - base_of(rg)) / 4;
      if (a[1:0] != 2'b00 || wi >= N) begin
        rg = 0;
        wi = 0;
      end
    end
  endtask

  function automatic string tag_of(input int rg);
    case (rg)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int rg, input int wi);
    case (rg)
      1: return m_rw[wi];
      2: return ro_status_i[wi*32 +: 32];
      3: return {m_bl_lk[wi], m_bl_d[wi]};
      4: return {m_wl_lk[wi], m_wl_d[wi]};
      5: return {hw_status_i[wi*16 +: 16], m_hl[wi]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_rw[i] = '0; m_bl_lk[i] = '0; m_bl_d[i] = '0;
      m_wl_lk[i] = 1'b0; m_wl_d[i] = '0; m_hl[i] = '0;
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < N; i++) begin
      chk({tag, " rw_ctrl"}, rw_ctrl_o[i*32 +: 32], m_rw[i]);
      chk({tag, " bl_ctrl"}, {16'h0, bl_ctrl_o[i*16 +: 16]}, {16'h0, m_bl_d[i]});
      chk({tag, " wl_ctrl"}, {1'b0, wl_ctrl_o[i*31 +: 31]}, {1'b0, m_wl_d[i]});
      chk({tag, " hw_ctrl"}, {16'h0, hw_ctrl_o[i*16 +: 16]}, {16'h0, m_hl[i]});
    end
  endtask

  // One bus request: driven on a falling edge, registered by the next rising
  // edge, sampled on the following falling edge (R9).
  task automatic access(input logic [15:0] a, input logic w, input logic r, input logic [31:0] d);
    int rg, wi;
    logic [31:0] exp_rd;
    logic        exp_err;
    classify(a, rg, wi);
    exp_rd  = r ? m_read(rg, wi) : 32'h0;
    exp_err = (rg == 0) || (w && rg == 2) || (w && rg == 4 && m_wl_lk[wi]);
    @(negedge clk);
    bus_addr = a; bus_wen = w; bus_ren = r; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0; bus_ren = 1'b0;
    if (w && !exp_err) begin
      case (rg)
        1: m_rw[wi] = d;
        3: begin
             m_bl_d[wi]  = (m_bl_d[wi] & m_bl_lk[wi]) | (d[15:0] & ~m_bl_lk[wi]);
             m_bl_lk[wi] = m_bl_lk[wi] | d[31:16];
           end
        4: begin m_wl_lk[wi] = d[31]; m_wl_d[wi] = d[30:0]; end
        5: m_hl[wi] = d[15:0];
        default: ;
      endcase
    end
    chk({tag_of(rg), " rdata"}, bus_rdata, exp_rd);
    chk({tag_of(rg), " err"}, {31'h0, bus_err}, {31'h0, exp_err});
    if (w) check_outputs(tag_of(rg));
  endtask

  task automatic set_status(input logic [31:0] seed);
    for (int i = 0; i < N; i++) begin
      ro_status_i[i*32 +: 32] = seed ^ (32'h1111_1111 * (i + 1));
      hw_status_i[i*16 +: 16] = seed[31:16] + 16'(i * 16'h0101);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] pats [6];
    logic [15:0] bad_addr [13];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hA5A5_5A5A;
    pats[3] = 32'h5A5A_A5A5; pats[4] = 32'h8001_7FFE; pats[5] = 32'h1234_5678;
    bad_addr[0]  = 16'h0000; bad_addr[1]  = 16'h0FFC; bad_addr[2]  = 16'h1010;
    bad_addr[3]  = 16'h10FC; bad_addr[4]  = 16'h1110; bad_addr[5]  = 16'h1001;
    bad_addr[6]  = 16'h1202; bad_addr[7]  = 16'h1210; bad_addr[8]  = 16'h13FC;
    bad_addr[9]  = 16'h1410; bad_addr[10] = 16'h1610; bad_addr[11] = 16'h1800;
    bad_addr[12] = 16'hFFFC;

    rst = 1'b1; bus_addr = '0; bus_wen = 1'b0; bus_ren = 1'b0; bus_wdata = '0;
    set_status(32'hC3A5_0F96);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10: reset state at the ports.
    check_outputs("R10");
    chk("R10 rdata", bus_rdata, 32'h0);
    chk("R10 err", {31'h0, bus_err}, 32'h0);
    for (int rg = 1; rg <= 5; rg++)
      for (int i = 0; i < N; i++)
        access(16'(base_of(rg) + 4 * i), 1'b0, 1'b1, 32'h0);

    // R1 R2 R7: data patterns on plain and half words, then on unlocked lock words (R4 R6).
    for (int p = 0; p < 6; p++)
      for (int i = 0; i < N; i++) begin
        access(16'(32'h1000 + 4 * i), 1'b1, 1'b0, pats[p] ^ (32'h0101_0101 << i));
        access(16'(32'h1000 + 4 * i), 1'b0, 1'b1, 32'h0);
        access(16'(32'h1600 + 4 * i), 1'b1, 1'b0, pats[p] ^ (32'h0303_0303 << i));
        access(16'(32'h1600 + 4 * i), 1'b0, 1'b1, 32'h0);
        access(16'(32'h1200 + 4 * i), 1'b1, 1'b0, (pats[p] ^ i) & 32'h0000_FFFF);
        access(16'(32'h1200 + 4 * i), 1'b0, 1'b1, 32'h0);
        access(16'(32'h1400 + 4 * i), 1'b1, 1'b0, (pats[p] ^ i) & 32'h7FFF_FFFF);
        access(16'(32'h1400 + 4 * i), 1'b0, 1'b1, 32'h0);
      end

    // R3: writes to status words are rejected and change nothing.
    for (int i = 0; i < N; i++) begin
      access(16'(32'h1100 + 4 * i), 1'b1, 1'b0, 32'hDEAD_BEEF);
      access(16'(32'h1100 + 4 * i), 1'b0, 1'b1, 32'h0);
    end
    // R3 R7: status is sampled at the read edge.
    set_status(32'h5E11_7A02);
    for (int i = 0; i < N; i++) begin
      access(16'(32'h1100 + 4 * i), 1'b0, 1'b1, 32'h0);
      access(16'(32'h1600 + 4 * i), 1'b0, 1'b1, 32'h0);
    end

    // R4: partial bit locks.
    access(16'h1200, 1'b1, 1'b0, 32'h0000_00FF);
    access(16'h1200, 1'b1, 1'b0, 32'h000F_0000);
    access(16'h1200, 1'b1, 1'b0, 32'h0000_FF00);
    access(16'h1200, 1'b0, 1'b1, 32'h0);
    // R4: data and lock loaded in one write; R5: zero write keeps the locks.
    access(16'h1204, 1'b1, 1'b0, 32'hFFFF_1234);
    access(16'h1204, 1'b1, 1'b0, 32'h0000_0000);
    access(16'h1204, 1'b0, 1'b1, 32'h0);
    access(16'h1200, 1'b1, 1'b0, 32'h0000_0000);
    access(16'h1200, 1'b0, 1'b1, 32'h0);

    // R6: word lock set with data, then writes rejected; R5 sticky.
    access(16'h1408, 1'b1, 1'b0, 32'h8000_0055);
    access(16'h1408, 1'b1, 1'b0, 32'h0000_0000);
    access(16'h1408, 1'b1, 1'b0, 32'h7FFF_FFFF);
    access(16'h1408, 1'b0, 1'b1, 32'h0);
    access(16'h140C, 1'b1, 1'b0, 32'hFFFF_FFFF);
    access(16'h140C, 1'b1, 1'b0, 32'h0000_0001);
    access(16'h140C, 1'b0, 1'b1, 32'h0);

    // R9: combined read and write returns the pre-write contents.
    access(16'h1004, 1'b1, 1'b1, 32'h0BAD_F00D);
    access(16'h1004, 1'b1, 1'b1, 32'h600D_CAFE);
    access(16'h1004, 1'b0, 1'b1, 32'h0);
    access(16'h1604, 1'b1, 1'b1, 32'hFFFF_0001);

    // R8: misses, both read and write.
    for (int k = 0; k < 13; k++) begin
      access(bad_addr[k], 1'b0, 1'b1, 32'h0);
      access(bad_addr[k], 1'b1, 1'b0, 32'hFFFF_FFFF);
    end

    // R5 R10: reset clears locks; the freed words then accept writes.
    do_reset();
    check_outputs("R5");
    for (int rg = 1; rg <= 5; rg++)
      for (int i = 0; i < N; i++)
        access(16'(base_of(rg) + 4 * i), 1'b0, 1'b1, 32'h0);
    access(16'h1204, 1'b1, 1'b0, 32'h0000_4321);
    access(16'h1204, 1'b0, 1'b1, 32'h0);
    access(16'h1408, 1'b1, 1'b0, 32'h0000_0AAA);
    access(16'h1408, 1'b0, 1'b1, 32'h0);

    finish_run();
  end

endmodule